// File: doc/BRIEF.md
# Maxima-Method Fuzzy Defuzzifier

This block turns the three aggregated rule strengths of a three-set fuzzy output variable into one crisp pixel intensity. The three output sets (low, medium, high) are triangles over the full intensity range. On each valid input the block picks the set whose strength is strictly larger than both others and clips that triangle at its strength. The top of the clipped shape is a flat plateau, and a two-bit method input chooses which point of that plateau is returned: its left end, its right end, or the midpoint between them.

The result is registered, so a crisp value and its valid flag appear one clock after the strengths are presented. The method is sampled on the same cycle as the strengths, so consecutive pixels may use different methods. When no strength is strictly largest, the output is zero. While the valid input is low, the output keeps its last value.

Top module: `fzd_maxima_defuzz`

## Requirements
- R1: After reset, `crisp_out` is 0 and `valid_out` is 0.
- R2: `valid_out` equals the `valid_in` of the previous clock cycle. With `valid_in` high in cycle n, `crisp_out` holds the result for the inputs of cycle n during cycle n+1.
- R3: When `str_low` is strictly greater than both other strengths (h = `str_low`), the plateau runs from 0 to 128 - floor(128*h/255).
- R4: When `str_med` is strictly greater than both others (h = `str_med`), the plateau runs from floor(128*h/255) to 255 - floor(127*h/255).
- R5: When `str_high` is strictly greater than both others (h = `str_high`), the plateau runs from 128 + floor(127*h/255) to 255.
- R6: `mode_sel` = 2'b00 returns the left end of the plateau.
- R7: `mode_sel` = 2'b01 returns floor((left + right) / 2). `mode_sel` = 2'b11 gives the same result as 2'b01.
- R8: `mode_sel` = 2'b10 returns the right end of the plateau.
- R9: When no strength is strictly greater than both others, including the case where all three are zero, the result is 0.
- R10: While `valid_in` is low, `crisp_out` keeps its value whatever the strengths and `mode_sel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Strengths and mode are valid this cycle |
| mode_sel | input | 2 | Method: 00 left end, 01 midpoint, 10 right end, 11 midpoint |
| str_low | input | 8 | Strength of the low output set |
| str_med | input | 8 | Strength of the medium output set |
| str_high | input | 8 | Strength of the high output set |
| valid_out | output | 1 | `crisp_out` was updated on the last edge |
| crisp_out | output | 8 | Crisp intensity |

## Verification
The bench sweeps every clip height for each winning set under all four method codes. This catches a wrong slope, an off-by-one in the floor division, and swapped plateau ends, any of which makes the output deviate at some height. Two-way and three-way ties are swept at every height, including all zero. A design that used a non-strict comparison would let one set win there and return a nonzero intensity. Runs with `valid_in` low and changing inputs expose a register that loads without qualification, because its output would move. Code 11 is checked against the midpoint so that a decoder falling through to another method is caught.

// File: rtl/fzd_pkg.sv
package fzd_pkg;
   typedef enum logic [1:0] {
      FZD_LEFT  = 2'b00,
      FZD_MID   = 2'b01,
      FZD_RIGHT = 2'b10,
      FZD_MID2  = 2'b11
   } fzd_mode_e;

   localparam int FZD_NSETS = 3;

   // Corner points of the triangular output sets, derived from the data width.
   // which: 0 = low set, 1 = medium set, 2 = high set. pt: 0 = left foot, 1 = peak, 2 = right foot.
   function automatic int fzd_corner(input int w, input int which, input int pt);
      int top;
      int mid;
      top = (1 << w) - 1;
      mid = 1 << (w - 1);
      case (which)
         0: return (pt == 0) ? 0   : (pt == 1) ? 0   : mid;
         1: return (pt == 0) ? 0   : (pt == 1) ? mid : top;
         default: return (pt == 0) ? mid : top;
      endcase
   endfunction
endpackage

// File: rtl/fzd_dominance.sv
module fzd_dominance #(
   parameter int W = 8
) (
   input  logic [W-1:0] s_low,
   input  logic [W-1:0] s_med,
   input  logic [W-1:0] s_high,
   output logic [2:0]   win,
   output logic [W-1:0] win_h
);
   logic low_gt_med, low_gt_high, med_gt_high, med_gt_low, high_gt_low, high_gt_med;

   always_comb begin
      low_gt_med  = s_low  > s_med;
      low_gt_high = s_low  > s_high;
      med_gt_low  = s_med  > s_low;
      med_gt_high = s_med  > s_high;
      high_gt_low = s_high > s_low;
      high_gt_med = s_high > s_med;
      win[0] = low_gt_med  & low_gt_high;
      win[1] = med_gt_low  & med_gt_high;
      win[2] = high_gt_low & high_gt_med;
      win_h  = '0;
      if (win[0]) win_h = s_low;
      if (win[1]) win_h = s_med;
      if (win[2]) win_h = s_high;
   end
endmodule

// File: rtl/fzd_plateau.sv
module fzd_plateau #(
   parameter int W  = 8,
   parameter int CA = 0,
   parameter int CP = 0,
   parameter int CB = 128
) (
   input  logic [W-1:0] h,
   output logic [W-1:0] left_end,
   output logic [W-1:0] right_end
);
   localparam int TOP = (1 << W) - 1;
   localparam int PW  = 2 * W;
   localparam logic [W-1:0]  RISE  = W'(CP - CA);
   localparam logic [W-1:0]  FALL  = W'(CB - CP);
   localparam logic [W-1:0]  A_W   = W'(CA);
   localparam logic [W-1:0]  B_W   = W'(CB);
   localparam logic [PW-1:0] DIVSR = PW'(TOP);

   if (CA > CP || CP > CB || CB > TOP) begin : g_bad_corner
      $error("fzd_plateau: triangle corners out of order or range");
   end

   logic [PW-1:0] rise_prod, fall_prod, rise_q, fall_q;

   always_comb begin
      rise_prod = {{W{1'b0}}, RISE} * {{W{1'b0}}, h};
      fall_prod = {{W{1'b0}}, FALL} * {{W{1'b0}}, h};
      rise_q    = rise_prod / DIVSR;
      fall_q    = fall_prod / DIVSR;
      left_end  = A_W + rise_q[W-1:0];
      right_end = B_W - fall_q[W-1:0];
   end
endmodule

// File: rtl/fzd_pick.sv
module fzd_pick
   import fzd_pkg::*;
#(
   parameter int W = 8
) (
   input  fzd_mode_e    mode,
   input  logic [W-1:0] left_end,
   input  logic [W-1:0] right_end,
   output logic [W-1:0] crisp
);
   logic [W:0] span_sum;

   always_comb begin
      span_sum = {1'b0, left_end} + {1'b0, right_end};
      unique case (mode)
         FZD_LEFT:  crisp = left_end;
         FZD_RIGHT: crisp = right_end;
         default:   crisp = span_sum[W:1];
      endcase
   end
endmodule

// File: rtl/fzd_maxima_defuzz.sv
module fzd_maxima_defuzz
   import fzd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_in,
   input  logic [1:0]   mode_sel,
   input  logic [W-1:0] str_low,
   input  logic [W-1:0] str_med,
   input  logic [W-1:0] str_high,
   output logic         valid_out,
   output logic [W-1:0] crisp_out
);
   if (W < 2 || W > 16) begin : g_bad_width
      $error("fzd_maxima_defuzz: W must lie in 2..16");
   end

   logic [2:0]   win;
   logic [W-1:0] win_h;
   logic [W-1:0] set_left  [FZD_NSETS];
   logic [W-1:0] set_right [FZD_NSETS];
   logic [W-1:0] sel_left, sel_right, crisp_nxt, pick_val;
   logic         any_win;

   fzd_dominance #(.W(W)) i_dom (
      .s_low(str_low), .s_med(str_med), .s_high(str_high),
      .win(win), .win_h(win_h)
   );

   for (genvar g = 0; g < FZD_NSETS; g++) begin : g_set
      fzd_plateau #(
         .W(W),
         .CA(fzd_corner(W, g, 0)),
         .CP(fzd_corner(W, g, 1)),
         .CB(fzd_corner(W, g, 2))
      ) i_plat (
         .h(win_h), .left_end(set_left[g]), .right_end(set_right[g])
      );
   end

   always_comb begin
      sel_left  = '0;
      sel_right = '0;
      for (int k = 0; k < FZD_NSETS; k++) begin
         if (win[k]) begin
            sel_left  = set_left[k];
            sel_right = set_right[k];
         end
      end
      any_win = |win;
   end

   fzd_pick #(.W(W)) i_pick (
      .mode(fzd_mode_e'(mode_sel)), .left_end(sel_left), .right_end(sel_right), .crisp(pick_val)
   );

   assign crisp_nxt = any_win ? pick_val : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         crisp_out <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) crisp_out <= crisp_nxt;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) valid_in |=> valid_out); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !valid_in |=> $stable(crisp_out)); // R10
   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win)); // R9
   AST_TIE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (valid_in && !any_win) |=> crisp_out == '0); // R9
   AST_PLATEAU_ORDER: assert property (@(posedge clk) disable iff (!rst_n) any_win |-> sel_left <= sel_right); // R6
endmodule

// File: tb/test_fzd_maxima_defuzz.sv
`timescale 1ns/1ps
module test_fzd_maxima_defuzz;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       valid_in = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [7:0] str_low = '0, str_med = '0, str_high = '0;
   logic       valid_out;
   logic [7:0] crisp_out;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fzd_maxima_defuzz #(.W(8)) i_fzd_maxima_defuzz (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode_sel(mode_sel),
      .str_low(str_low), .str_med(str_med), .str_high(str_high),
      .valid_out(valid_out), .crisp_out(crisp_out)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model(input int l, input int m, input int h, input int md);
      int lo, hi, x;
      if (l > m && l > h) begin x = l; lo = 0; hi = 128 - (128 * x) / 255; end
      else if (m > l && m > h) begin x = m; lo = (128 * x) / 255; hi = 255 - (127 * x) / 255; end
      else if (h > l && h > m) begin x = h; lo = 128 + (127 * x) / 255; hi = 255; end
      else return 0;
      if (md == 0) return lo;
      if (md == 2) return hi;
      return (lo + hi) / 2;
   endfunction

   function automatic string set_tag(input int w);
      if (w == 0) return "R3";
      if (w == 1) return "R4";
      return "R5";
   endfunction

   function automatic string mode_tag(input int md);
      if (md == 0) return "R6";
      if (md == 2) return "R8";
      return "R7";
   endfunction

   task automatic apply(input int l, input int m, input int h, input int md, input string tag);
      str_low = 8'(l); str_med = 8'(m); str_high = 8'(h); mode_sel = 2'(md);
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
      check({tag, " value"}, int'(crisp_out), model(l, m, h, md));
      check("R2 valid_out", int'(valid_out), 1);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int top, o1, o2;
      @(negedge clk); @(negedge clk);
      check("R1 crisp_out reset", int'(crisp_out), 0);
      check("R1 valid_out reset", int'(valid_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 idle valid_out", int'(valid_out), 0);

      for (int md = 0; md < 4; md++)
         for (int w = 0; w < 3; w++)
            for (int x = 1; x < 256; x++) begin
               o1 = x / 2;
               o2 = x - 1;
               if (w == 0) apply(x, o1, o2, md, {set_tag(w), " ", mode_tag(md)});
               else if (w == 1) apply(o2, x, o1, md, {set_tag(w), " ", mode_tag(md)});
               else apply(o1, o2, x, md, {set_tag(w), " ", mode_tag(md)});
            end

      for (int x = 0; x < 256; x++) begin
         apply(x, x, x / 3, x % 4, "R9 low/med tie");
         apply(x / 4, x, x, (x + 1) % 4, "R9 med/high tie");
         apply(x, x / 5, x, (x + 2) % 4, "R9 low/high tie");
         apply(x, x, x, (x + 3) % 4, "R9 triple tie");
      end

      for (int x = 1; x < 256; x += 7) begin
         apply(0, x, 0, 3, "R4 R7 code 11");
         top = int'(crisp_out);
         for (int k = 0; k < 3; k++) begin
            str_low = 8'(x * 3 + k); str_med = 8'(k); str_high = 8'(255 - x);
            mode_sel = 2'(k);
            @(negedge clk);
            check("R10 hold value", int'(crisp_out), top);
            check("R2 valid_out low", int'(valid_out), 0);
         end
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule